// File: doc/BRIEF.md
# ADC Sample Buffer with Level Interrupts

This block sits between a conversion sequencer and a host. The sequencer hands over 16-bit conversion results one per cycle on a valid/data pair. The block stores them in order in an on-chip queue, and the host drains the queue through a data register. The host sees the queue's fill level as three active-low flags in a status word.

Two interrupt sources are latched. The first fires when the fill level rises to half of the depth. The second fires when a programmed number of accepted samples has been counted. Each source has its own enable bit and its own clear bit in the control register. The host clears a source by setting the clear bit and then writing it back to zero. A pending word shows which sources are active, and a single interrupt line reports that at least one is pending.

Clearing the buffer-enable bit empties the queue. A sample that arrives while the queue is full is discarded, and a sticky flag records the loss.

Top module: `adc_sample_buffer`

## Requirements
- R1: After reset the status word reads 0x3 (full_n=1, half_n=1, avail=0, lost=0), the pending word reads 0 and `irq` is low.
- R2: Samples are returned by DATA (address 2) reads in the order they were accepted. Each read removes one sample. A DATA read on an empty queue returns 0 and leaves the queue unchanged.
- R3: Status word (address 1) layout: bit0 full_n, bit1 half_n, bit2 avail, bit3 lost. With fewer than DEPTH/2 samples it reads {1,1,avail}. From DEPTH/2 to DEPTH-1 samples it reads full_n=1, half_n=0, avail=1. At DEPTH samples it reads full_n=0, half_n=0, avail=1. avail is 1 exactly when at least one sample is held.
- R4: The three level flags only ever show one of the four combinations listed in R3.
- R5: A sample offered while the queue holds DEPTH entries is discarded and sets lost (bit3). lost stays set, even after the queue is drained, until the queue is flushed.
- R6: Control (address 0) bit0 enables the queue. While it is 0 the queue is held empty, lost is cleared, the sample count restarts and offered samples are ignored.
- R7: With control bit1 set, the half-level source becomes pending in the cycle the fill level goes from DEPTH/2-1 to DEPTH/2. It shows as bit2 of the pending word (address 3).
- R8: While control bit2 is 1 the half-level pending bit is cleared. Writing bit2 high then low clears it without changing the queue contents or the status word.
- R9: With a non-zero target written at address 4 and control bit3 set, the count source becomes pending on every target-th accepted sample. It shows as bit7 of the pending word. Control bit4 set-then-clear clears it, and writing the target restarts the count.
- R10: `irq` is high exactly when a pending bit is set. A source whose enable bit is 0 never becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Producer offers a sample this cycle |
| smp_data | input | DATA_W | Offered sample |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions check the following on every cycle:
- the three flags never show an illegal combination;
- a full queue never grows;
- an empty queue never shrinks;
- a flush always empties the queue;
- lost stays set until a flush;
- a held clear bit removes its pending source;
- the sample counter stays below its target.

Some behaviour needs the bench's scenarios:
- data ordering across mixed random pushes and pops;
- the exact cycle at which the half level is crossed;
- the contents surviving an interrupt clear;
- the discarded sample not appearing when the queue is drained.

// File: rtl/asb_pkg.sv
// Shared register addresses and control bit positions for the sample buffer.
package asb_pkg;
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_DATA = 3'd2,
        REG_PEND = 3'd3,
        REG_SCNT = 3'd4
    } reg_addr_e;

    localparam int CB_EN     = 0;
    localparam int CB_HF_EN  = 1;
    localparam int CB_HF_CLR = 2;
    localparam int CB_SC_EN  = 3;
    localparam int CB_SC_CLR = 4;
    localparam int CTRL_W    = 5;

    localparam int NSRC   = 2;
    localparam int SRC_HF = 0;
    localparam int SRC_SC = 1;

    localparam int PEND_BIT_HF = 2;
    localparam int PEND_BIT_SC = 7;
endpackage

// File: rtl/asb_fifo.sv
// Sample queue: storage array, read/write pointers and an occupancy counter.
// Assumes DEPTH is a power of two. A write into a full queue is dropped and
// sets a sticky lost flag. A level-high flush empties the queue and clears lost.
module asb_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       wr_acc,
    output logic                       lost,
    output logic                       half_cross
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     count_nx;
    logic              rd_acc;
    logic              is_full, is_empty;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign wr_acc   = wr && !flush && !is_full;
    assign rd_acc   = rd && !flush && !is_empty;
    assign rd_data  = mem[rp];

    // Next occupancy from accepted pushes and pops.
    always_comb begin
        count_nx = count;
        if (flush)
            count_nx = '0;
        else if (wr_acc && !rd_acc)
            count_nx = count + 1'b1;
        else if (rd_acc && !wr_acc)
            count_nx = count - 1'b1;
    end

    // Pulse when the level rises through the half mark.
    assign half_cross = (count < CW'(HALF)) && (count_nx >= CW'(HALF));

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_acc)
            mem[wp] <= wr_data;
    end

    // Pointers, occupancy and sticky lost flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            lost  <= 1'b0;
        end else begin
            if (wr_acc) wp <= wp + 1'b1;
            if (rd_acc) rp <= rp + 1'b1;
            count <= count_nx;
            if (wr && is_full) lost <= 1'b1;
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr && !rd && !flush) |=> (count == CW'(DEPTH) && lost)); // R5
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !flush) |=> lost); // R5
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd && !wr) |=> (count == '0)); // R2
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !lost)); // R6
endmodule

// File: rtl/asb_level_flags.sv
// Decodes the queue occupancy into three active-low level flags.
// Assumes count never exceeds DEPTH.
module asb_level_flags #(
    parameter int DEPTH = 2048
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] count,
    output logic                   full_n,
    output logic                   half_n,
    output logic                   avail
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    // Flag decode: at the full level both full_n and half_n drop.
    always_comb begin
        avail  = (count != '0);
        full_n = (count != CW'(DEPTH));
        half_n = (count < CW'(HALF));
    end

    AST_FLAGS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({full_n, half_n, avail} inside {3'b111, 3'b101, 3'b001, 3'b110})); // R4
endmodule

// File: rtl/asb_irq_src.sv
// One latched interrupt source. It becomes pending on an enabled event and
// is held clear while its clear bit is high (set-then-clear to acknowledge).
module asb_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic evt,
    output logic pend
);
    // Latch or clear the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend <= 1'b0;
        else if (en && evt)
            pend <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend); // R8
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend); // R10
endmodule

// File: rtl/asb_sample_counter.sv
// Counts accepted samples and pulses done on every target-th one.
// Assumes a zero target disables the source. Load or clear restarts the count.
module asb_sample_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] target_in,
    input  logic             tick,
    output logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = tick && (target != '0) && (cnt == target - 1'b1);

    // Target register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target <= '0;
        else if (load)
            target <= target_in;
    end

    // Running count, wrapped on done.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || load)
            cnt <= '0;
        else if (done)
            cnt <= '0;
        else if (tick && target != '0)
            cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (target != '0) |-> (cnt < target)); // R9
endmodule

// File: rtl/adc_sample_buffer.sv
// Top level: host register file, read path, queue, flags and interrupt sources.
// Assumes one register access per cycle. Read data appears one cycle after reg_rd.
module adc_sample_buffer
    import asb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CTRL_W-1:0] ctrl;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] head;
    logic              wr_acc, lost, half_cross;
    logic              full_n, half_n, avail;
    logic              sc_done, pop, scnt_load;
    logic [CNT_W-1:0]  target;
    logic [NSRC-1:0]   src_en, src_clr, src_evt, src_pend;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[31:CNT_W];
    assign pop       = reg_rd && (reg_addr_e'(reg_addr) == REG_DATA);
    assign scnt_load = reg_wr && (reg_addr_e'(reg_addr) == REG_SCNT);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (reg_wr && reg_addr_e'(reg_addr) == REG_CTRL)
            ctrl <= reg_wdata[CTRL_W-1:0];
    end

    asb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!ctrl[CB_EN]),
        .wr(smp_valid), .wr_data(smp_data), .rd(pop), .rd_data(head),
        .count(count), .wr_acc(wr_acc), .lost(lost), .half_cross(half_cross)
    );

    asb_level_flags #(.DEPTH(DEPTH)) i_flags (
        .clk(clk), .rst_n(rst_n), .count(count),
        .full_n(full_n), .half_n(half_n), .avail(avail)
    );

    asb_sample_counter #(.CNT_W(CNT_W)) i_scnt (
        .clk(clk), .rst_n(rst_n), .clear(!ctrl[CB_EN]), .load(scnt_load),
        .target_in(reg_wdata[CNT_W-1:0]), .tick(wr_acc),
        .target(target), .done(sc_done)
    );

    assign src_en[SRC_HF]  = ctrl[CB_HF_EN];
    assign src_clr[SRC_HF] = ctrl[CB_HF_CLR];
    assign src_evt[SRC_HF] = half_cross;
    assign src_en[SRC_SC]  = ctrl[CB_SC_EN];
    assign src_clr[SRC_SC] = ctrl[CB_SC_CLR];
    assign src_evt[SRC_SC] = sc_done;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        asb_irq_src i_src (
            .clk(clk), .rst_n(rst_n), .en(src_en[g]), .clr(src_clr[g]),
            .evt(src_evt[g]), .pend(src_pend[g])
        );
    end

    assign irq = |src_pend;

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            case (reg_addr_e'(reg_addr))
                REG_CTRL: reg_rdata <= 32'(ctrl);
                REG_STAT: reg_rdata <= {28'd0, lost, avail, half_n, full_n};
                REG_DATA: reg_rdata <= avail ? 32'(head) : 32'd0;
                REG_PEND: begin
                    reg_rdata[PEND_BIT_HF] <= src_pend[SRC_HF];
                    reg_rdata[PEND_BIT_SC] <= src_pend[SRC_SC];
                end
                REG_SCNT: reg_rdata <= 32'(target);
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: tb/test_adc_sample_buffer.sv
`timescale 1ns/1ps
module test_adc_sample_buffer;
    localparam int DEPTH = 2048;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] q[$];
    bit m_en = 0, m_lost = 0;

    always #4 clk = ~clk;

    adc_sample_buffer i_adc_sample_buffer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int exp_stat(int n, bit l);
        int s;
        s = (n == DEPTH) ? 32'h4 : (n >= HALF) ? 32'h5 : (n > 0) ? 32'h7 : 32'h3;
        return s | (l ? 32'h8 : 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
        if (a == 3'd0) begin
            m_en = d[0];
            if (!m_en) begin q.delete(); m_lost = 0; end
        end
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(logic [15:0] v);
        @(negedge clk); smp_valid = 1'b1; smp_data = v;
        @(posedge clk); @(negedge clk); smp_valid = 1'b0;
        if (m_en) begin
            if (q.size() < DEPTH) q.push_back(v); else m_lost = 1;
        end
    endtask

    task automatic pop_chk(string req);
        logic [31:0] d;
        int e;
        e = (q.size() > 0) ? int'(q[0]) : 0;
        rd_reg(3'd2, d);
        if (q.size() > 0) void'(q.pop_front());
        chk(req, int'(d), e);
    endtask

    task automatic stat_chk(string req);
        logic [31:0] d;
        rd_reg(3'd1, d);
        chk(req, int'(d), exp_stat(q.size(), m_lost));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        stat_chk("R1 status");
        rd_reg(3'd3, d); chk("R1 pending", int'(d), 0);
        chk("R1 irq", int'(irq), 0);

        // R2/R3 directed order
        wr_reg(3'd0, 32'h1);
        for (int i = 0; i < 5; i++) push(16'($urandom));
        stat_chk("R3 few samples");
        for (int i = 0; i < 5; i++) pop_chk("R2 order");
        stat_chk("R3 empty again");
        rd_reg(3'd2, d); chk("R2 empty read", int'(d), 0);
        stat_chk("R2 empty read no change");
        push(16'hBEEF); pop_chk("R2 after empty read");

        // R2/R3/R4 random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) != 0 && q.size() < 40) push(16'($urandom));
            else pop_chk("R2 random");
            if (i % 40 == 0) stat_chk("R4 random flags");
        end

        // R7 half crossing
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd0, 32'h3);
        for (int i = 0; i < HALF - 1; i++) push(16'($urandom));
        stat_chk("R3 below half");
        chk("R7 no irq below half", int'(irq), 0);
        push(16'h1234);
        chk("R7 irq at half", int'(irq), 1);
        rd_reg(3'd3, d); chk("R7 pending bit2", int'(d), 32'h4);
        stat_chk("R3 half level");
        // R8 set-then-clear
        wr_reg(3'd0, 32'h7);
        wr_reg(3'd0, 32'h3);
        chk("R8 irq cleared", int'(irq), 0);
        stat_chk("R8 contents kept");
        pop_chk("R8 data kept");
        push(16'h4321);
        chk("R7 recross latches", int'(irq), 1);
        wr_reg(3'd0, 32'h7);
        wr_reg(3'd0, 32'h3);

        // R5 full and drop
        while (q.size() < DEPTH) push(16'($urandom));
        stat_chk("R3 full");
        push(16'hDEAD);
        stat_chk("R5 lost set");
        while (q.size() > 1) pop_chk("R5 drain");
        pop_chk("R5 last is not dropped sample");
        stat_chk("R5 lost sticky after drain");

        // R6 flush and disabled writes
        wr_reg(3'd0, 32'h0);
        stat_chk("R6 flush clears");
        push(16'h1111); push(16'h2222);
        wr_reg(3'd0, 32'h1);
        stat_chk("R6 disabled pushes ignored");
        for (int i = 0; i < 4; i++) push(16'($urandom));
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd0, 32'h1);
        stat_chk("R6 flush with content");

        // R10 disabled half source
        for (int i = 0; i < HALF; i++) push(16'($urandom));
        chk("R10 disabled hf no irq", int'(irq), 0);
        rd_reg(3'd3, d); chk("R10 pending zero", int'(d), 0);

        // R9 sample count
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd0, 32'h9);
        wr_reg(3'd4, 32'd3);
        push(16'd1); push(16'd2);
        chk("R9 before target", int'(irq), 0);
        push(16'd3);
        chk("R9 at target", int'(irq), 1);
        rd_reg(3'd3, d); chk("R9 pending bit7", int'(d), 32'h80);
        wr_reg(3'd0, 32'h19);
        wr_reg(3'd0, 32'h9);
        chk("R9 cleared", int'(irq), 0);
        push(16'd4); push(16'd5);
        chk("R9 second period early", int'(irq), 0);
        push(16'd6);
        chk("R9 second period", int'(irq), 1);
        stat_chk("R9 contents");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule